// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Phase Alignment

This block derives two timing strobes from the device clock: a frame boundary pulse and a multiframe boundary pulse. On a wide serial-link datapath each device-clock cycle carries several octets, so the block counts multiframes in datapath beats. A multiframe holds FRAME_OCTETS × MF_FRAMES octets, and each beat carries BEAT_OCTETS of them. An external SYSREF strobe, sampled on the device clock, sets the phase of both counters. The reload lands a fixed ALIGN_DELAY cycles after the clock edge that first samples SYSREF high. Because this delay never changes, devices that share the strobe all line up on the same multiframe boundary.

The block accepts three kinds of SYSREF: a single pulse, a continuous periodic signal, or a periodic signal with gaps. It checks each later SYSREF edge against the running phase. An edge that lands on a multiframe boundary changes nothing. An edge that lands anywhere else sets a sticky misalignment flag. When realignment is enabled, that edge also reloads the phase. When realignment is disabled, the block keeps its phase and reports that it has lost lock. The clock generator may stop SYSREF once lock is reached. If the link then asks for resynchronisation, the block raises a request for a fresh SYSREF and holds it until an edge arrives.

The phase logic is a state machine with three states:
- SEEK: no alignment yet; the pulses are held low.
- LOCKED: aligned.
- SLIPPED: a misaligned edge was seen while realignment was disabled.

Its transitions are:
- SEEK→LOCKED on the first load.
- LOCKED→LOCKED on an edge that lands on a boundary, or on a misaligned edge with realignment enabled.
- LOCKED→SLIPPED on a misaligned edge with realignment disabled.
- SLIPPED→LOCKED on an edge that lands on a boundary of the running phase, or on any edge with realignment enabled.

The request logic has two states:
- IDLE→WAIT on a rising resynchronisation request while SYSREF is gated off.
- WAIT→IDLE on a SYSREF rising edge.

Parameter limits:
- MF_FRAMES must lie in 1..32.
- FRAME_OCTETS × MF_FRAMES must lie in 17..1024.
- FRAME_OCTETS × MF_FRAMES must be a multiple of BEAT_OCTETS.
- ALIGN_DELAY must be at least 1.

Top module: `mfclk_lmfc_gen`

## Requirements
- R1: While reset is asserted and after it is released, and until the first alignment, `lmfc_o`, `frame_o`, `aligned_o`, `misalign_o` and `sysref_req_o` are all 0.
- R2: Let E0 be the rising clock edge at which `sysref_i` is first sampled high. The multiframe phase becomes zero at edge E0+ALIGN_DELAY, where ALIGN_DELAY is 2 by default. `lmfc_o` and `aligned_o` are 1 in the cycle after that edge and not before it.
- R3: Once aligned, `lmfc_o` is a one-cycle pulse repeated every FRAME_OCTETS×MF_FRAMES/BEAT_OCTETS cycles, which is 8 by default.
- R4: `frame_o` is 1 in every cycle whose beat contains the first octet of a frame. With the defaults (8-octet frames, 4-octet beats) that is every second cycle, and it includes every `lmfc_o` cycle.
- R5: Only a rising edge of `sysref_i` counts. Holding it high for many cycles has no further effect on the phase or on `misalign_o`.
- R6: A later SYSREF edge whose reload instant coincides with a multiframe boundary leaves the phase unchanged, keeps `aligned_o` at 1, and keeps `misalign_o` at 0.
- R7: A later SYSREF edge whose reload instant falls inside a multiframe sets `misalign_o`, which stays 1 until reset. With `realign_en_i`=1 the phase is reloaded, so `lmfc_o`=1 in the cycle after E0+ALIGN_DELAY, and `aligned_o` stays 1.
- R8: With `realign_en_i`=0, a misaligned edge leaves the phase unchanged and drops `aligned_o` to 0. A later edge that lands on a boundary of the running phase brings `aligned_o` back to 1.
- R9: A rising edge on `resync_req_i`, sampled while `sysref_gated_i`=1, sets `sysref_req_o` from the next cycle. The request stays high until a SYSREF rising edge is detected, and is 0 in the cycle after E0+1.
- R10: A rising edge on `resync_req_i` while `sysref_gated_i`=0 does not raise `sysref_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_i | input | 1 | External SYSREF strobe, synchronous to the device clock |
| realign_en_i | input | 1 | 1: a misaligned SYSREF reloads the phase |
| resync_req_i | input | 1 | Link resynchronisation request, active high |
| sysref_gated_i | input | 1 | 1: the clock generator currently sends no SYSREF |
| lmfc_o | output | 1 | One-cycle multiframe boundary pulse |
| frame_o | output | 1 | Frame boundary pulse |
| aligned_o | output | 1 | Phase locked to SYSREF |
| misalign_o | output | 1 | Sticky: a SYSREF edge landed inside a multiframe |
| sysref_req_o | output | 1 | Request for a fresh SYSREF |

## Verification
The assertions take for granted that `sysref_i` and `resync_req_i` are synchronous to the device clock. They also assume that the configuration makes a multiframe a whole number of beats, so a naturally spaced multiframe pulse is never mistaken for a reload. The bench drives every input on the falling edge. It uses only the default configuration. It places each SYSREF edge at a cycle offset computed from the eight-beat multiframe and the two-cycle delay, so that each edge is either exactly on a boundary or deliberately several beats off one.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;

    typedef enum logic [1:0] {
        AL_SEEK    = 2'd0,
        AL_LOCKED  = 2'd1,
        AL_SLIPPED = 2'd2
    } align_state_t;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_WAIT = 1'b1
    } req_state_t;

endpackage

// File: rtl/mfclk_sysref_capture.sv
// Registers SYSREF, detects its rising edge, and delays that edge
// into a reload strobe.
module mfclk_sysref_capture #(
    parameter int unsigned ALIGN_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_i,
    output logic edge_o,
    output logic strobe_o
);
    logic sr_q;
    logic sr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= 1'b0;
            sr_d <= 1'b0;
        end else begin
            sr_q <= sysref_i;
            sr_d <= sr_q;
        end
    end

    assign edge_o = sr_q & ~sr_d;

    generate
        if (ALIGN_DELAY <= 1) begin : g_direct
            assign strobe_o = edge_o;
        end else begin : g_line
            localparam int unsigned STAGES = ALIGN_DELAY - 1;
            logic line [0:STAGES];
            assign line[0] = edge_o;
            for (genvar gi = 1; gi <= STAGES; gi++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        line[gi] <= 1'b0;
                    end else begin
                        line[gi] <= line[gi-1];
                    end
                end
            end
            assign strobe_o = line[STAGES];
        end
    endgenerate
endmodule

// File: rtl/mfclk_phase_counter.sv
// Counts beats within a multiframe and tracks the octet offset within
// the current frame.
module mfclk_phase_counter #(
    parameter int unsigned BEATS        = 8,
    parameter int unsigned FRAME_OCTETS = 8,
    parameter int unsigned BEAT_OCTETS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic mf_start_o,
    output logic fr_start_o,
    output logic at_last_o
);
    localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int unsigned OW = $clog2(FRAME_OCTETS + BEAT_OCTETS) + 1;

    logic [CW-1:0] cnt;
    logic [OW-1:0] off;
    logic [OW-1:0] off_next;

    assign at_last_o = (cnt == CW'(BEATS - 1));
    assign off_next  = OW'((int'(off) + int'(BEAT_OCTETS)) % int'(FRAME_OCTETS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            off <= '0;
        end else if (load_i || at_last_o) begin
            cnt <= '0;
            off <= '0;
        end else begin
            cnt <= cnt + CW'(1);
            off <= off_next;
        end
    end

    assign mf_start_o = (cnt == '0);
    // The beat spans octets [off, off+BEAT_OCTETS): a frame start lies inside it
    // when the offset is zero or the frame ends before the beat does.
    assign fr_start_o = (off == '0) ||
                        (int'(off) > int'(FRAME_OCTETS) - int'(BEAT_OCTETS));
endmodule

// File: rtl/mfclk_sysref_request.sv
// Raises a request for a new SYSREF when resynchronisation is asked for
// while SYSREF is gated off; clears it on the next SYSREF edge.
module mfclk_sysref_request
    import mfclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resync_req_i,
    input  logic sysref_gated_i,
    input  logic sr_edge_i,
    output logic req_o
);
    req_state_t state_q;
    req_state_t state_d;
    logic       resync_q;
    logic       resync_rise;

    assign resync_rise = resync_req_i & ~resync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RQ_IDLE;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resync_q <= resync_req_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: if (resync_rise && sysref_gated_i && !sr_edge_i) state_d = RQ_WAIT;
            RQ_WAIT: if (sr_edge_i) state_d = RQ_IDLE;
            default: state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == RQ_WAIT);
    end
endmodule

// File: rtl/mfclk_lmfc_gen.sv
module mfclk_lmfc_gen
    import mfclk_pkg::*;
#(
    parameter int unsigned FRAME_OCTETS = 8,
    parameter int unsigned MF_FRAMES    = 4,
    parameter int unsigned BEAT_OCTETS  = 4,
    parameter int unsigned ALIGN_DELAY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_i,
    input  logic realign_en_i,
    input  logic resync_req_i,
    input  logic sysref_gated_i,
    output logic lmfc_o,
    output logic frame_o,
    output logic aligned_o,
    output logic misalign_o,
    output logic sysref_req_o
);
    localparam int unsigned MF_OCTETS = FRAME_OCTETS * MF_FRAMES;
    localparam int unsigned MF_BEATS  = MF_OCTETS / BEAT_OCTETS;

    align_state_t state_q;
    align_state_t state_d;
    logic sr_edge;
    logic strobe;
    logic load;
    logic mis_set;
    logic mis_q;
    logic mf_start;
    logic fr_start;
    logic at_last;

    mfclk_sysref_capture #(.ALIGN_DELAY(ALIGN_DELAY)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sysref_i (sysref_i),
        .edge_o   (sr_edge),
        .strobe_o (strobe)
    );

    mfclk_phase_counter #(
        .BEATS        (MF_BEATS),
        .FRAME_OCTETS (FRAME_OCTETS),
        .BEAT_OCTETS  (BEAT_OCTETS)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .mf_start_o (mf_start),
        .fr_start_o (fr_start),
        .at_last_o  (at_last)
    );

    mfclk_sysref_request u_request (
        .clk            (clk),
        .rst_n          (rst_n),
        .resync_req_i   (resync_req_i),
        .sysref_gated_i (sysref_gated_i),
        .sr_edge_i      (sr_edge),
        .req_o          (sysref_req_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AL_SEEK;
            mis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mis_set) mis_q <= 1'b1;
        end
    end

    // Next state. A strobe is on a boundary when the running count would
    // wrap to zero at the same edge anyway.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        mis_set = 1'b0;
        unique case (state_q)
            AL_SEEK: begin
                if (strobe) begin
                    load    = 1'b1;
                    state_d = AL_LOCKED;
                end
            end
            AL_LOCKED: begin
                if (strobe && !at_last) begin
                    mis_set = 1'b1;
                    if (realign_en_i) load = 1'b1;
                    else              state_d = AL_SLIPPED;
                end
            end
            AL_SLIPPED: begin
                if (strobe) begin
                    if (at_last) begin
                        state_d = AL_LOCKED;
                    end else if (realign_en_i) begin
                        load    = 1'b1;
                        state_d = AL_LOCKED;
                    end
                end
            end
            default: state_d = AL_SEEK;
        endcase
    end

    // Outputs
    always_comb begin
        aligned_o  = (state_q == AL_LOCKED);
        lmfc_o     = (state_q != AL_SEEK) && mf_start;
        frame_o    = (state_q != AL_SEEK) && fr_start;
        misalign_o = mis_q;
    end
endmodule

// File: rtl/mfclk_lmfc_gen_checker.sv
module mfclk_lmfc_gen_checker
    import mfclk_pkg::*;
#(
    parameter int unsigned MF_BEATS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic lmfc_o,
    input logic frame_o,
    input logic aligned_o,
    input logic misalign_o,
    input logic sysref_req_o,
    input logic sr_edge,
    input logic load
);
    localparam int unsigned GW = $clog2(MF_BEATS + 1) + 1;

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (lmfc_o) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != {GW{1'b1}}) begin
            gap <= gap + GW'(1);
        end
    end

    // R1 / R2: no pulses before the first alignment
    p_silent_before_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned_o && !misalign_o) |-> (!lmfc_o && !frame_o));

    // R3: pulses not at the natural spacing only follow a reload
    p_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lmfc_o && seen && (gap != GW'(MF_BEATS - 1))) |-> $past(load));

    // R4: a multiframe boundary is a frame boundary
    p_mf_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_o |-> frame_o);

    // R7: misalignment flag is sticky
    p_misalign_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |=> misalign_o);

    // R9: request held until a SYSREF edge
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sysref_req_o && !sr_edge) |=> sysref_req_o);

    // R9: request dropped after a SYSREF edge
    p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sysref_req_o && sr_edge) |=> !sysref_req_o);
endmodule

bind mfclk_lmfc_gen mfclk_lmfc_gen_checker #(.MF_BEATS(MF_BEATS)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lmfc_o       (lmfc_o),
    .frame_o      (frame_o),
    .aligned_o    (aligned_o),
    .misalign_o   (misalign_o),
    .sysref_req_o (sysref_req_o),
    .sr_edge      (sr_edge),
    .load         (load)
);

// File: tb/mfclk_lmfc_gen_test.sv
module mfclk_lmfc_gen_test;
    localparam int MF = 8;   // beats per multiframe with defaults
    localparam int D  = 2;   // reload delay
    localparam int ON_BOUNDARY_WAIT = 2 * MF - D - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sysref_i = 1'b0;
    logic realign_en_i = 1'b0;
    logic resync_req_i = 1'b0;
    logic sysref_gated_i = 1'b0;
    logic lmfc_o, frame_o, aligned_o, misalign_o, sysref_req_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mfclk_lmfc_gen #(
        .FRAME_OCTETS(8), .MF_FRAMES(4), .BEAT_OCTETS(4), .ALIGN_DELAY(D)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sysref_i(sysref_i),
        .realign_en_i(realign_en_i), .resync_req_i(resync_req_i),
        .sysref_gated_i(sysref_gated_i), .lmfc_o(lmfc_o), .frame_o(frame_o),
        .aligned_o(aligned_o), .misalign_o(misalign_o), .sysref_req_o(sysref_req_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise SYSREF for 'len' cycles; returns at the falling edge after E0+len-1.
    task automatic send_sysref(input int len);
        sysref_i = 1'b1;
        tick(len);
        sysref_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(5);
        check("R1 lmfc in reset", int'(lmfc_o), 0);
        check("R1 req in reset", int'(sysref_req_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            check("R1 lmfc before align", int'(lmfc_o), 0);
            check("R1 frame before align", int'(frame_o), 0);
            check("R1 aligned before align", int'(aligned_o), 0);
            check("R1 misalign before align", int'(misalign_o), 0);
        end
    endtask

    // Ends at the cycle where the phase is zero.
    task automatic t_first_align();
        send_sysref(1);
        tick(D - 1);
        check("R2 lmfc one cycle early", int'(lmfc_o), 0);
        check("R2 aligned one cycle early", int'(aligned_o), 0);
        tick(1);
        check("R2 lmfc at reload", int'(lmfc_o), 1);
        check("R2 aligned at reload", int'(aligned_o), 1);
        check("R4 frame at reload", int'(frame_o), 1);
    endtask

    task automatic t_period();
        for (int i = 1; i <= 2 * MF; i++) begin
            tick(1);
            check("R3 lmfc spacing", int'(lmfc_o), (i % MF == 0) ? 1 : 0);
            check("R4 frame spacing", int'(frame_o), (i % 2 == 0) ? 1 : 0);
        end
    endtask

    task automatic t_boundary();
        tick(ON_BOUNDARY_WAIT);
        send_sysref(1);
        tick(D);
        check("R6 lmfc after on-boundary edge", int'(lmfc_o), 1);
        check("R6 misalign after on-boundary edge", int'(misalign_o), 0);
        check("R6 aligned after on-boundary edge", int'(aligned_o), 1);
    endtask

    task automatic t_held();
        tick(ON_BOUNDARY_WAIT);
        send_sysref(12);            // now 1 beat past a boundary
        tick(MF - 1);
        check("R5 lmfc after held level", int'(lmfc_o), 1);
        check("R5 misalign after held level", int'(misalign_o), 0);
        check("R5 aligned after held level", int'(aligned_o), 1);
    endtask

    task automatic t_realign();
        realign_en_i = 1'b1;
        tick(ON_BOUNDARY_WAIT + 3);
        send_sysref(1);
        tick(D);
        check("R7 lmfc after realign", int'(lmfc_o), 1);
        check("R7 misalign set", int'(misalign_o), 1);
        check("R7 aligned kept", int'(aligned_o), 1);
        tick(MF);
        check("R7 new phase period", int'(lmfc_o), 1);
        check("R7 misalign sticky", int'(misalign_o), 1);
    endtask

    task automatic t_slip();
        realign_en_i = 1'b0;
        tick(ON_BOUNDARY_WAIT + 3);  // reload instant 3 beats into a multiframe
        send_sysref(1);
        tick(D);
        check("R8 phase kept, no pulse", int'(lmfc_o), 0);
        check("R8 aligned dropped", int'(aligned_o), 0);
        check("R8 misalign set", int'(misalign_o), 1);
        tick(MF - 3);
        check("R8 old phase boundary", int'(lmfc_o), 1);
        tick(ON_BOUNDARY_WAIT);
        send_sysref(1);
        tick(D);
        check("R8 relock on boundary", int'(aligned_o), 1);
        check("R8 lmfc on relock", int'(lmfc_o), 1);
    endtask

    task automatic t_no_request();
        sysref_gated_i = 1'b0;
        resync_req_i = 1'b1;
        tick(2);
        check("R10 no request when not gated", int'(sysref_req_o), 0);
        resync_req_i = 1'b0;
        tick(1);
    endtask

    task automatic t_request();
        sysref_gated_i = 1'b1;
        resync_req_i = 1'b1;
        tick(1);
        check("R9 request raised", int'(sysref_req_o), 1);
        resync_req_i = 1'b0;
        tick(5);
        check("R9 request held", int'(sysref_req_o), 1);
        send_sysref(1);
        check("R9 request held at edge cycle", int'(sysref_req_o), 1);
        tick(1);
        check("R9 request cleared", int'(sysref_req_o), 0);
        sysref_gated_i = 1'b0;
    endtask

    initial begin
        tick(1);
        t_reset();
        t_first_align();
        t_period();
        t_boundary();
        t_held();
        t_realign();
        t_slip();
        t_no_request();
        t_request();
        tick(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule